// File: doc/BRIEF.md
# Byte-Lane Bank Chip-Select Decoder

This block sits between a 32-bit system bus and a memory region built from byte-wide devices. The devices are arranged in rows of four, one device per byte lane, and a row may be repeated to fill a larger region. Each cycle the block looks at the word address (the two lowest byte-address bits are never driven on the bus), the four active-low byte enables and the active-low read and write strobes. It then produces one active-high chip select per device, the device-internal word address and an out-of-range flag, all registered one clock after the request.

Each chip select is the AND of three terms. The first is a region hit: the address bits above the region size equal the base, which must be aligned to the region size. The second is a bank term, decoded from the address bits that lie between the top of the device address range and the region size. The third is that lane's byte enable. A combinational helper converts a transfer size and byte offset into the byte-enable pattern a requester would drive.

A small state register classifies every sampled request. ST_IDLE means no access: no strobe is active, or no byte enable is active. ST_SEL means a legal hit, and the chip selects are driven. ST_MISS means an access that misses the region or drives both strobes at once. Every state can move to every other state on each clock, according to the request sampled at that edge. The transitions are idle-to-select, select-to-miss and so on, and each state can also hold. The out-of-range flag is high exactly while the state is ST_MISS.

Top module: `bank_cs_decoder`

## Requirements
- R1: While reset is asserted, all chip selects, the out-of-range flag and the device address are 0.
- R2: Outputs reflect the request sampled at the previous rising clock edge (one cycle of latency), and consecutive requests produce consecutive results with no gap.
- R3: The device address equals byte address bits 16..2, which is the byte address divided by four, truncated to the device depth of 32K words.
- R4: A request hits when byte address bits 31..18 equal those of the base 0x84000000. Byte address bit 17 then selects the bank: 0 selects bank 0 and 1 selects bank 1. Chip selects of at most one bank are ever active.
- R5: Chip select index bank*4+lane is high exactly when the request is a legal hit in that bank and the lane's byte enable is low. Lane 0 is bits 7..0 and lane 3 is bits 31..24.
- R6: With both strobes high, or with all four byte enables high, no chip select is active and the out-of-range flag stays low.
- R7: A request with exactly one strobe low, at least one byte enable low and a region miss sets the out-of-range flag and activates no chip select.
- R8: A request with both strobes low and at least one byte enable low is illegal. It sets the out-of-range flag and activates no chip select.
- R9: The byte-enable helper maps a size code (0 byte, 1 half-word, 2 word) and a byte offset to the bit pattern lane3..lane0 as follows: word at offset 0 gives 0000, half at offset 0 gives 1100, half at offset 2 gives 0011, and byte at offset k gives all ones except bit k. A misaligned or undefined request gives 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 30 | Byte address bits 31..2 |
| be_n | input | 4 | Active-low byte enables, bit k = lane k |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| req_size | input | 2 | Helper size code |
| req_off | input | 2 | Helper byte offset |
| req_be_n | output | 4 | Helper byte-enable pattern |
| cs | output | 8 | Chip selects, index bank*4+lane |
| dev_addr | output | 15 | Device-internal word address |
| range_err | output | 1 | Out-of-range or illegal access |

## Verification
The stimulus covers a full-word read in bank 0, a high half-word write in bank 1, a single byte at the last word of bank 0, and bytes on each lane in turn. These separate the lane mapping from the bank split. Addresses just above the region and in a distant region test the high compare, and they do so apart from the bank bit. Idle strobes, all-high byte enables and clashing strobes are placed between hits, so that a stale chip select or a wrong state transition becomes visible. The helper is swept over every size and offset, aligned and misaligned.

// File: rtl/bank_cs_pkg.sv
package bank_cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_MISS = 2'd2
    } dec_state_e;
endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int          ADDR_W    = 32,
    parameter int          LANE_LG   = 2,
    parameter int          REGION_LG = 18,
    parameter logic [63:0] BASE_ADDR = 64'h8400_0000
) (
    input  logic [ADDR_W-1:LANE_LG] addr,
    output logic                    hit
);
    localparam logic [ADDR_W-1:0] BASE_V = BASE_ADDR[ADDR_W-1:0];

    // Only the bits above the aligned region size take part.
    always_comb begin
        hit = (addr[ADDR_W-1:REGION_LG] == BASE_V[ADDR_W-1:REGION_LG]);
    end
endmodule

// File: rtl/bank_select.sv
module bank_select #(
    parameter int NBANK = 2,
    parameter int IDX_W = 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [NBANK-1:0] bank_oh
);
    generate
        if (NBANK == 1) begin : g_single
            logic unused_idx;
            assign unused_idx = ^idx;
            assign bank_oh    = 1'b1;
        end else begin : g_multi
            for (genvar b = 0; b < NBANK; b++) begin : g_dec
                assign bank_oh[b] = (idx == IDX_W'(b));
            end
        end
    endgenerate
endmodule

// File: rtl/lane_qual.sv
module lane_qual #(
    parameter int LANES = 4,
    parameter int NBANK = 2
) (
    input  logic                   enable,
    input  logic [NBANK-1:0]       bank_oh,
    input  logic [LANES-1:0]       be_n,
    output logic [NBANK*LANES-1:0] cs
);
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            for (genvar l = 0; l < LANES; l++) begin : g_lane
                // Every lane of one bank shares the same bank term.
                assign cs[b*LANES+l] = enable & bank_oh[b] & ~be_n[l];
            end
        end
    endgenerate
endmodule

// File: rtl/be_gen.sv
module be_gen #(
    parameter int LANES   = 4,
    parameter int LANE_LG = 2,
    parameter int SIZE_W  = 2
) (
    input  logic [SIZE_W-1:0]  req_size,
    input  logic [LANE_LG-1:0] req_off,
    output logic [LANES-1:0]   req_be_n
);
    always_comb begin
        int nbytes;
        int off;
        logic legal;
        off    = int'(req_off);
        legal  = (int'(req_size) <= LANE_LG);
        nbytes = legal ? (1 << int'(req_size)) : 1;
        if (legal && ((off % nbytes) != 0)) legal = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            req_be_n[l] = !(legal && (l >= off) && (l < off + nbytes));
        end
    end
endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
    import bank_cs_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          LANES     = 4,
    parameter logic [63:0] BASE_ADDR = 64'h8400_0000,
    parameter int          REGION_LG = 18,
    parameter int          DEV_LG    = 15,
    localparam int LANE_LG = $clog2(LANES),
    localparam int BANK_LO = LANE_LG + DEV_LG,
    localparam int BANK_W  = REGION_LG - BANK_LO,
    localparam int NBANK   = 1 << BANK_W,
    localparam int CS_W    = NBANK * LANES,
    localparam int SIZE_W  = $clog2(LANE_LG + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:LANE_LG] bus_addr,
    input  logic [LANES-1:0]        be_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [SIZE_W-1:0]       req_size,
    input  logic [LANE_LG-1:0]      req_off,
    output logic [LANES-1:0]        req_be_n,
    output logic [CS_W-1:0]         cs,
    output logic [DEV_LG-1:0]       dev_addr,
    output logic                    range_err
);
    localparam int IDX_W = (BANK_W > 0) ? BANK_W : 1;

    dec_state_e       state, nxt;
    logic             hit;
    logic [IDX_W-1:0] bank_idx;
    logic [NBANK-1:0] bank_oh;
    logic [CS_W-1:0]  lane_cs;
    logic             any_be;
    logic             no_strobe;
    logic             clash;

    region_match #(
        .ADDR_W(ADDR_W), .LANE_LG(LANE_LG),
        .REGION_LG(REGION_LG), .BASE_ADDR(BASE_ADDR)
    ) u_match (
        .addr(bus_addr), .hit(hit)
    );

    generate
        if (BANK_W > 0) begin : g_idx
            assign bank_idx = bus_addr[REGION_LG-1:BANK_LO];
        end else begin : g_noidx
            assign bank_idx = '0;
        end
    endgenerate

    bank_select #(.NBANK(NBANK), .IDX_W(IDX_W)) u_bank (
        .idx(bank_idx), .bank_oh(bank_oh)
    );

    lane_qual #(.LANES(LANES), .NBANK(NBANK)) u_lane (
        .enable(nxt == ST_SEL), .bank_oh(bank_oh), .be_n(be_n), .cs(lane_cs)
    );

    be_gen #(.LANES(LANES), .LANE_LG(LANE_LG), .SIZE_W(SIZE_W)) u_begen (
        .req_size(req_size), .req_off(req_off), .req_be_n(req_be_n)
    );

    assign any_be    = ~&be_n;
    assign no_strobe = rd_n & wr_n;
    assign clash     = ~rd_n & ~wr_n;

    // Classify the request present at this edge.
    always_comb begin
        if (no_strobe || !any_be)      nxt = ST_IDLE;
        else if (clash || !hit)        nxt = ST_MISS;
        else                           nxt = ST_SEL;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs       <= '0;
            dev_addr <= '0;
        end else begin
            cs       <= lane_cs;
            dev_addr <= bus_addr[BANK_LO-1:LANE_LG];
        end
    end

    always_comb begin
        unique case (state)
            ST_MISS: range_err = 1'b1;
            ST_SEL:  range_err = 1'b0;
            default: range_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/bank_cs_checker.sv
module bank_cs_checker #(
    parameter int ADDR_W    = 32,
    parameter int LANES     = 4,
    parameter int REGION_LG = 18,
    parameter int DEV_LG    = 15,
    localparam int LANE_LG = $clog2(LANES),
    localparam int BANK_LO = LANE_LG + DEV_LG,
    localparam int NBANK   = 1 << (REGION_LG - BANK_LO),
    localparam int CS_W    = NBANK * LANES,
    localparam int SIZE_W  = $clog2(LANE_LG + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:LANE_LG] bus_addr,
    input logic [LANES-1:0]        be_n,
    input logic                    rd_n,
    input logic                    wr_n,
    input logic [SIZE_W-1:0]       req_size,
    input logic [LANE_LG-1:0]      req_off,
    input logic [LANES-1:0]        req_be_n,
    input logic [CS_W-1:0]         cs,
    input logic [DEV_LG-1:0]       dev_addr,
    input logic                    range_err
);
    logic [NBANK-1:0] bank_any;
    for (genvar b = 0; b < NBANK; b++) begin : g_any
        assign bank_any[b] = |cs[b*LANES +: LANES];
    end

    p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_any));

    p_err_no_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> (cs == '0));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_n && wr_n)) |-> (cs == '0 && !range_err));

    p_dev_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dev_addr == $past(bus_addr[BANK_LO-1:LANE_LG])));

    p_clash_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!rd_n && !wr_n && (be_n != '1))) |-> range_err);

    p_word_pattern_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == SIZE_W'(LANE_LG) && req_off == '0) |-> (req_be_n == '0));

    for (genvar b = 0; b < NBANK; b++) begin : g_bk
        for (genvar l = 0; l < LANES; l++) begin : g_ln
            p_lane_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
                cs[b*LANES+l] |-> ($past(rst_n) && !$past(be_n[l])));
        end
    end
endmodule

bind bank_cs_decoder bank_cs_checker #(
    .ADDR_W(ADDR_W), .LANES(LANES), .REGION_LG(REGION_LG), .DEV_LG(DEV_LG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .be_n(be_n),
    .rd_n(rd_n), .wr_n(wr_n), .req_size(req_size), .req_off(req_off),
    .req_be_n(req_be_n), .cs(cs), .dev_addr(dev_addr), .range_err(range_err)
);

// File: tb/bank_cs_decoder_test.sv
module bank_cs_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] a;
    logic [3:0]  be_n;
    logic        rd_n, wr_n;
    logic [1:0]  req_size, req_off;
    logic [3:0]  req_be_n;
    logic [7:0]  cs;
    logic [14:0] dev_addr;
    logic        range_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_cs;
    logic       exp_err;
    int         exp_dev;
    string      prev_tag;

    always #10 clk = ~clk;

    bank_cs_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(a[31:2]), .be_n(be_n),
        .rd_n(rd_n), .wr_n(wr_n), .req_size(req_size), .req_off(req_off),
        .req_be_n(req_be_n), .cs(cs), .dev_addr(dev_addr), .range_err(range_err)
    );

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Behavioural reference for one request.
    task automatic model();
        int lows;
        int bank;
        bit hit;
        lows    = (rd_n ? 0 : 1) + (wr_n ? 0 : 1);
        hit     = ((a >> 18) == (32'h8400_0000 >> 18));
        bank    = (a >> 17) & 1;
        exp_dev = (a >> 2) % 32768;
        exp_cs  = 8'h00;
        exp_err = 1'b0;
        if (lows == 0 || be_n == 4'hF) begin
        end else if (lows == 2 || !hit) begin
            exp_err = 1'b1;
        end else begin
            for (int l = 0; l < 4; l++)
                if (!be_n[l]) exp_cs[bank*4 + l] = 1'b1;
        end
    endtask

    task automatic compare();
        check({prev_tag, " cs"}, cs, exp_cs);
        check({prev_tag, " err"}, range_err, exp_err);
        check({prev_tag, " dev_addr"}, dev_addr, exp_dev);
    endtask

    task automatic apply(string tag, logic [31:0] addr, logic [3:0] be,
                         logic r, logic w);
        @(negedge clk);
        compare();
        a = addr; be_n = be; rd_n = r; wr_n = w;
        model();
        prev_tag = tag;
    endtask

    task automatic gen_chk(int size, int off);
        int nb;
        logic [3:0] e;
        req_size = 2'(size); req_off = 2'(off);
        #1;
        nb = 1 << size;
        if (size > 2 || (off % nb) != 0) e = 4'hF;
        else e = ~(4'(((1 << nb) - 1) << off));
        check($sformatf("R9 size=%0d off=%0d", size, off), req_be_n, e);
    endtask

    initial begin
        rst_n = 1'b0; a = 32'h8400_0010; be_n = 4'h0; rd_n = 1'b0; wr_n = 1'b1;
        req_size = 2'd0; req_off = 2'd0;
        repeat (3) @(negedge clk);
        check("R1 reset cs", cs, 0);
        check("R1 reset err", range_err, 0);
        check("R1 reset dev", dev_addr, 0);
        rst_n = 1'b1;
        model();
        prev_tag = "R2 first after reset";

        apply("R5 word read bank0",      32'h8400_0000, 4'b0000, 0, 1);
        apply("R4 high half bank1",      32'h8402_0004, 4'b0011, 1, 0);
        apply("R3 byte1 last word",      32'h8401_FFFC, 4'b1101, 0, 1);
        apply("R6 no strobe",            32'h8400_0008, 4'b0000, 1, 1);
        apply("R6 no byte enable",       32'h8400_0008, 4'b1111, 0, 1);
        apply("R7 miss above region",    32'h8404_0000, 4'b0000, 0, 1);
        apply("R5 low half bank1",       32'h8403_FFF8, 4'b1100, 1, 0);
        apply("R7 miss far region",      32'h4000_0000, 4'b1110, 1, 0);
        apply("R8 both strobes",         32'h8400_0100, 4'b0000, 0, 0);
        apply("R8 both strobes no be",   32'h8400_0100, 4'b1111, 0, 0);
        for (int l = 0; l < 4; l++)
            apply($sformatf("R5 lane%0d bank%0d", l, l & 1),
                  32'h8400_0000 | (32'((l & 1)) << 17) | (32'(l) << 2),
                  ~(4'b0001 << l), 1'(l & 1), 1'(~l & 1));
        apply("R2 back to idle",         32'h0000_0000, 4'b1111, 1, 1);
        apply("R2 flush",                32'h0000_0000, 4'b1111, 1, 1);

        // Named patterns then a full sweep.
        gen_chk(2, 0); gen_chk(1, 0); gen_chk(1, 2); gen_chk(0, 0); gen_chk(0, 1);
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                gen_chk(s, o);
        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 5000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule